// File: doc/BRIEF.md
# Angle Converter Register Bank with Self-Test Control

This block is the memory-mapped register file that sits between a host bus and twelve angle-converter channels. Every clock cycle it captures each channel's 16-bit angle result and its health signal. It keeps a small per-channel configuration of resolution and loop bandwidth, and it drives those settings out to the converters. A single control/status word drives one inhibit line per channel. While a channel's inhibit line is high, its stored result is frozen, so software reads a stable value. The same word also drives the self-test controls that replace the converters' sine and cosine inputs with fixed levels. The converters themselves are outside the block and are modelled as inputs.

The bus addresses 32-bit words by word index, where index = byte offset / 4. A write takes effect on the clock edge that samples it. A read returns its data on `bus_rdata` one cycle after the strobe, and `bus_rdata` keeps that value until the next read. The health flag in bit 31 of each channel word is inverted: 1 means the channel has lost tracking, so a 32-bit signed read of a failing channel is negative. Bit 31 of the control/status word is the OR of all channel flags, so one sign test covers every channel.

Top module: `rb_bank`

## Requirements
- R1: Word index i (byte offset 4*i), for i = 0 to 11, reads channel i. Bits 15:0 hold the angle result latched from `conv_angle[16*i+15:16*i]`, and bits 27:16 read zero.
- R2: Bit 31 of a channel word reads 1 when that channel's `conv_ok` input was low on the capturing edge. It reads 0 when the channel is healthy and self-test is off.
- R3: Bits 11:0 of the control/status word (index 15, byte offset 0x3C) are read/write. Bit i drives `inhibit[i]`.
- R4: Channel-word bit 30 (bandwidth select, read/write) drives `cfg_bw[i]`. Bits 29:28 (resolution select, read/write) drive `cfg_res[2*i+1:2*i]`, coded 0=10, 1=12, 2=14 and 3=16 bits.
- R5: Indices 12 to 14 (byte offsets 0x30 to 0x3B) read as zero, and writes to them change no register.
- R6: Writes to read-only bits have no effect. These are the result field, bit 31 and bits 27:16 of a channel word, and bits 31:16 and 12 of the control/status word.
- R7: Control bit 13 enables self-test and is driven on `tst_en`. Bit 14 selects the cosine test level and bit 15 the sine test level. `tst_cos` and `tst_sin` are high only while self-test is enabled, and all three bits read back as written.
- R8: While self-test is enabled, bit 31 of every channel word reads 1 whatever the `conv_ok` inputs are.
- R9: Bit 31 of the control/status word equals the OR of the twelve channel flags.
- R10: While `inhibit[i]` is high, channel i's result field keeps its last latched value. After the bit clears, it tracks the input again.
- R11: Synchronous active-high reset clears the configuration, inhibit and self-test bits, the stored results and `bus_rdata`.
- R12: `bus_rdata` changes only one cycle after a read strobe (`bus_sel` high, `bus_wr` low) and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_widx | input | 4 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| conv_angle | input | 192 | Angle result of each channel, 16 bits per channel, channel 0 in the low bits |
| conv_ok | input | 12 | Per-channel converter health, 1 = tracking |
| inhibit | output | 12 | Per-channel result freeze lines |
| cfg_bw | output | 12 | Per-channel bandwidth select |
| cfg_res | output | 24 | Per-channel resolution code, 2 bits per channel |
| tst_en | output | 1 | Self-test enable: converter inputs switched to test levels |
| tst_cos | output | 1 | Cosine test input at reference level |
| tst_sin | output | 1 | Sine test input at reference level |

## Verification
The assertions check the following on every cycle:
- A write to the control word or to channel 0 shows on the inhibit, configuration and test outputs on the next cycle.
- Reserved reads return zero.
- The status sign bit matches the OR of the channel flags.
- Every channel read made during a settled self-test reports failure.
- The read port holds its value between reads.

Some behaviour only the bench scenarios can show:
- That the result freeze under inhibit keeps the exact older angle while the inputs move on.
- That a channel picks the input up again as soon as its inhibit clears.
- That a single failing channel shows only in its own word.
- That writes of all-ones to read-only fields and reserved words leave every readable word unchanged.

// File: rtl/rb_pkg.sv
package rb_pkg;
  // Bit positions that software and the converters both depend on
  localparam int FLAG_BIT    = 31;
  localparam int BW_BIT      = 30;
  localparam int RES_HI_BIT  = 29;
  localparam int RES_LO_BIT  = 28;
  localparam int TST_EN_BIT  = 13;
  localparam int TST_COS_BIT = 14;
  localparam int TST_SIN_BIT = 15;
  localparam int WORD_W      = 32;

  typedef enum logic [1:0] {
    RES_10 = 2'd0,
    RES_12 = 2'd1,
    RES_14 = 2'd2,
    RES_16 = 2'd3
  } res_sel_t;

  typedef struct packed {
    logic     bw;
    res_sel_t res;
  } chan_cfg_t;
endpackage

// File: rtl/rb_chan_slice.sv
module rb_chan_slice
  import rb_pkg::*;
#(
  parameter int RW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_din,
  input  logic [RW-1:0]     angle_in,
  input  logic              ok_in,
  input  logic              hold,
  input  logic              test_on,
  output logic [WORD_W-1:0] word_o,
  output logic              flag_o,
  output chan_cfg_t         cfg_o
);
  localparam int PAD = WORD_W - 4 - RW;

  chan_cfg_t     cfg_q;
  logic [RW-1:0] res_q;
  logic          flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      res_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cfg_wr) begin
        cfg_q.bw  <= cfg_din[2];
        cfg_q.res <= res_sel_t'(cfg_din[1:0]);
      end
      if (!hold) res_q <= angle_in;
      flag_q <= test_on | ~ok_in;
    end
  end

  assign word_o = {flag_q, cfg_q.bw, cfg_q.res, {PAD{1'b0}}, res_q};
  assign flag_o = flag_q;
  assign cfg_o  = cfg_q;
endmodule

// File: rtl/rb_ctrl.sv
module rb_ctrl
  import rb_pkg::*;
#(
  parameter int NCH = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [15:0]       din,
  input  logic [NCH-1:0]    flags,
  output logic [NCH-1:0]    inh_o,
  output logic              en_o,
  output logic              cos_o,
  output logic              sin_o,
  output logic [WORD_W-1:0] word_o
);
  logic [NCH-1:0] inh_q;
  logic           en_q, cos_q, sin_q;
  logic           unused_din;

  assign unused_din = ^din[12];

  always_ff @(posedge clk) begin
    if (rst) begin
      inh_q <= '0;
      en_q  <= 1'b0;
      cos_q <= 1'b0;
      sin_q <= 1'b0;
    end else if (wr_en) begin
      inh_q <= din[NCH-1:0];
      en_q  <= din[TST_EN_BIT];
      cos_q <= din[TST_COS_BIT];
      sin_q <= din[TST_SIN_BIT];
    end
  end

  always_comb begin
    word_o              = '0;
    word_o[NCH-1:0]     = inh_q;
    word_o[TST_EN_BIT]  = en_q;
    word_o[TST_COS_BIT] = cos_q;
    word_o[TST_SIN_BIT] = sin_q;
    word_o[FLAG_BIT]    = |flags;
  end

  assign inh_o = inh_q;
  assign en_o  = en_q;
  assign cos_o = en_q & cos_q;
  assign sin_o = en_q & sin_q;
endmodule

// File: rtl/rb_rdmux.sv
module rb_rdmux
  import rb_pkg::*;
#(
  parameter int NCH = 12,
  parameter int AW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [AW-1:0]     idx,
  input  logic [WORD_W-1:0] chan_words [NCH],
  input  logic [WORD_W-1:0] ctrl_word,
  output logic [WORD_W-1:0] rdata
);
  localparam logic [AW-1:0] CTRL_IDX = {AW{1'b1}};

  logic [WORD_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NCH; i++) begin
      if (idx == AW'(i)) pick = chan_words[i];
    end
    if (idx == CTRL_IDX) pick = ctrl_word;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= pick;
  end
endmodule

// File: rtl/rb_bank.sv
module rb_bank
  import rb_pkg::*;
#(
  parameter int NCH = 12,
  parameter int RW  = 16,
  parameter int AW  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_widx,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [NCH*RW-1:0]   conv_angle,
  input  logic [NCH-1:0]      conv_ok,
  output logic [NCH-1:0]      inhibit,
  output logic [NCH-1:0]      cfg_bw,
  output logic [2*NCH-1:0]    cfg_res,
  output logic                tst_en,
  output logic                tst_cos,
  output logic                tst_sin
);
  localparam logic [AW-1:0] CTRL_IDX = {AW{1'b1}};

  logic [WORD_W-1:0] chan_words [NCH];
  logic [WORD_W-1:0] ctrl_word;
  logic [NCH-1:0]    flag_vec;
  logic              wr_stb, rd_stb;
  logic              unused_wbits;

  assign wr_stb       = bus_sel & bus_wr;
  assign rd_stb       = bus_sel & ~bus_wr;
  assign unused_wbits = ^{bus_wdata[31], bus_wdata[27:16]};

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    chan_cfg_t cfg_w;
    rb_chan_slice #(.RW(RW)) u_slice (
      .clk      (clk),
      .rst      (rst),
      .cfg_wr   (wr_stb && bus_widx == AW'(g)),
      .cfg_din  (bus_wdata[BW_BIT:RES_LO_BIT]),
      .angle_in (conv_angle[g*RW +: RW]),
      .ok_in    (conv_ok[g]),
      .hold     (inhibit[g]),
      .test_on  (tst_en),
      .word_o   (chan_words[g]),
      .flag_o   (flag_vec[g]),
      .cfg_o    (cfg_w)
    );
    assign cfg_bw[g]          = cfg_w.bw;
    assign cfg_res[2*g +: 2]  = cfg_w.res;
  end

  rb_ctrl #(.NCH(NCH)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_stb && bus_widx == CTRL_IDX),
    .din    (bus_wdata[15:0]),
    .flags  (flag_vec),
    .inh_o  (inhibit),
    .en_o   (tst_en),
    .cos_o  (tst_cos),
    .sin_o  (tst_sin),
    .word_o (ctrl_word)
  );

  rb_rdmux #(.NCH(NCH), .AW(AW)) u_rdmux (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_stb),
    .idx        (bus_widx),
    .chan_words (chan_words),
    .ctrl_word  (ctrl_word),
    .rdata      (bus_rdata)
  );
endmodule

// File: rtl/rb_bank_chk.sv
module rb_bank_chk #(
  parameter int NCH = 12,
  parameter int AW  = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_widx,
  input logic [31:0]     bus_wdata,
  input logic [31:0]     bus_rdata,
  input logic [NCH-1:0]  inhibit,
  input logic [NCH-1:0]  cfg_bw,
  input logic [2*NCH-1:0] cfg_res,
  input logic            tst_en,
  input logic            tst_sin,
  input logic [NCH-1:0]  flag_vec
);
  localparam logic [AW-1:0] CTRL_IDX = {AW{1'b1}};

  logic ctrl_wr, ctrl_rd, ch0_wr, rsv_rd, chan_rd, any_rd;
  assign ctrl_wr = bus_sel && bus_wr && bus_widx == CTRL_IDX;
  assign ctrl_rd = bus_sel && !bus_wr && bus_widx == CTRL_IDX;
  assign ch0_wr  = bus_sel && bus_wr && bus_widx == '0;
  assign rsv_rd  = bus_sel && !bus_wr && bus_widx >= AW'(NCH) && bus_widx != CTRL_IDX;
  assign chan_rd = bus_sel && !bus_wr && bus_widx < AW'(NCH);
  assign any_rd  = bus_sel && !bus_wr;

  a_r3_inhibit_write: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> inhibit == $past(bus_wdata[NCH-1:0]));

  a_r4_cfg_write: assert property (@(posedge clk) disable iff (rst)
    ch0_wr |=> (cfg_bw[0] == $past(bus_wdata[30])) && (cfg_res[1:0] == $past(bus_wdata[29:28])));

  a_r7_test_write: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (tst_en == $past(bus_wdata[13])) && (tst_sin == $past(bus_wdata[15] & bus_wdata[13])));

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    rsv_rd |=> bus_rdata == 32'h0);

  a_r8_test_flags: assert property (@(posedge clk) disable iff (rst)
    (chan_rd && tst_en && $past(tst_en)) |=> bus_rdata[31]);

  a_r9_status_or: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd |=> bus_rdata[31] == $past(|flag_vec));

  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !any_rd |=> $stable(bus_rdata));
endmodule

bind rb_bank rb_bank_chk #(.NCH(NCH), .AW(AW)) u_rb_bank_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_widx  (bus_widx),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .inhibit   (inhibit),
  .cfg_bw    (cfg_bw),
  .cfg_res   (cfg_res),
  .tst_en    (tst_en),
  .tst_sin   (tst_sin),
  .flag_vec  (flag_vec)
);

// File: tb/test_rb_bank.sv
`timescale 1ns/1ps
module test_rb_bank;
  localparam int NCH = 12;
  localparam int RW  = 16;
  localparam int AW  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0]     bus_widx = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NCH*RW-1:0] conv_angle = '0;
  logic [NCH-1:0]    conv_ok = '1;
  logic [NCH-1:0]    inhibit, cfg_bw;
  logic [2*NCH-1:0]  cfg_res;
  logic              tst_en, tst_cos, tst_sin;

  always #2 clk = ~clk;

  rb_bank #(.NCH(NCH), .RW(RW), .AW(AW)) i_rb_bank (.*);

  int n_chk = 0, n_bad = 0;

  // independent model
  logic [15:0]    m_ang [NCH];
  logic [15:0]    cur_ang [NCH];
  logic           m_bw [NCH];
  logic [1:0]     m_res [NCH];
  logic [NCH-1:0] m_inh = '0;
  logic           m_en = 0, m_cos = 0, m_sin = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int idx);
    logic [31:0] w = '0;
    if (idx < NCH) begin
      w = {m_en | ~conv_ok[idx], m_bw[idx], m_res[idx], 12'h000, m_ang[idx]};
    end else if (idx == 15) begin
      w[NCH-1:0] = m_inh;
      w[13] = m_en; w[14] = m_cos; w[15] = m_sin;
      for (int i = 0; i < NCH; i++) w[31] = w[31] | m_en | ~conv_ok[i];
    end
    return w;
  endfunction

  task automatic do_write(input int idx, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_widx = AW'(idx); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    if (idx < NCH) begin
      m_bw[idx] = d[30]; m_res[idx] = d[29:28];
    end else if (idx == 15) begin
      m_inh = d[NCH-1:0]; m_en = d[13]; m_cos = d[14]; m_sin = d[15];
      for (int i = 0; i < NCH; i++) if (!m_inh[i]) m_ang[i] = cur_ang[i];
    end
    @(negedge clk);
  endtask

  task automatic do_read(input int idx, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_widx = AW'(idx);
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    for (int k = 0; k < 16; k++) begin
      do_read(k, d);
      chk(req, d, exp_word(k));
    end
  endtask

  task automatic set_angles(input int pat);
    for (int i = 0; i < NCH; i++) begin
      cur_ang[i] = 16'((pat * 16'h1357) + (i * 16'h0F0F) + 1);
      conv_angle[i*RW +: RW] = cur_ang[i];
      if (!m_inh[i]) m_ang[i] = cur_ang[i];
    end
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, held;
    for (int i = 0; i < NCH; i++) begin
      m_ang[i] = 0; cur_ang[i] = 0; m_bw[i] = 0; m_res[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    // R11 reset state
    chk("R11 rdata", bus_rdata, 32'h0);
    chk("R11 outputs", {8'h0, inhibit, cfg_bw}, 32'h0);
    chk("R11 cfg_res/test", {5'h0, cfg_res, tst_en, tst_cos, tst_sin}, 32'h0);
    @(negedge clk);
    check_all("R11 words");

    // R1 angle capture, several patterns
    for (int p = 1; p <= 4; p++) begin
      set_angles(p);
      check_all("R1 result");
    end

    // R4/R6 configuration with all-ones in read-only fields
    for (int i = 0; i < NCH; i++)
      do_write(i, {1'b1, 1'(i >> 2), 2'(i), 28'hFFFFFFF});
    check_all("R4 R6 channel words");
    for (int i = 0; i < NCH; i++) begin
      chk("R4 cfg_bw", 32'(cfg_bw[i]), 32'(m_bw[i]));
      chk("R4 cfg_res", 32'(cfg_res[2*i +: 2]), 32'(m_res[i]));
    end

    // R2/R9 walking failure
    for (int k = 0; k < NCH; k++) begin
      conv_ok = ~(NCH'(1) << k);
      @(negedge clk);
      do_read(k, d);
      chk("R2 failing flag", 32'(d[31]), 32'h1);
      do_read((k + 1) % NCH, d);
      chk("R2 healthy flag", 32'(d[31]), 32'h0);
      do_read(15, d);
      chk("R9 status or", d, exp_word(15));
    end
    conv_ok = '1;
    @(negedge clk);
    check_all("R9 all healthy");

    // R3/R10 inhibit freeze and release
    do_write(15, 32'h0000_0A5A);
    chk("R3 inhibit out", 32'(inhibit), 32'h0A5A);
    set_angles(7);
    check_all("R10 held");
    do_write(15, 32'h0000_05A5);
    chk("R3 inhibit out", 32'(inhibit), 32'h05A5);
    set_angles(9);
    check_all("R10 swap");
    do_write(15, 32'h0);
    check_all("R10 released");

    // R7/R8 self-test combinations
    for (int c = 0; c < 4; c++) begin
      do_write(15, {16'h0, 1'(c >> 1), 1'(c), 1'b1, 13'h0});
      chk("R7 test outputs", {29'h0, tst_en, tst_cos, tst_sin},
          {29'h0, 1'b1, 1'(c), 1'(c >> 1)});
      check_all("R8 self-test words");
    end
    do_write(15, 32'h0000_C000);
    chk("R7 gated when disabled", {29'h0, tst_en, tst_cos, tst_sin}, 32'h0);
    check_all("R7 readback");

    // R6 read-only bits of control word
    do_write(15, 32'hFFFF_1000);
    check_all("R6 control word");
    do_write(15, 32'h0);

    // R5 reserved writes
    for (int k = NCH; k < 15; k++) do_write(k, 32'hFFFF_FFFF);
    check_all("R5 reserved");

    // R12 rdata holds without a read
    do_read(3, held);
    set_angles(11);
    do_write(3, 32'h0);
    repeat (3) @(negedge clk);
    chk("R12 rdata hold", bus_rdata, held);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule